// File: doc/BRIEF.md
# Data Access Guard

The data access guard inspects every data memory access on its way out of a processor core. It takes the request address, a load/store flag and a valid strobe, together with the current contents of several control registers held elsewhere: the process identifier, the system control word, two breakpoint address words, the breakpoint control word and the debug control/status word. From these it forms the address that will actually be issued and decides whether the access must be aborted for misalignment and whether it matches a data breakpoint.

Low addresses are first relocated into the current process slot. The relocated address is then checked for alignment and compared against two address watch units. The watch units can work independently, each with its own load/store qualifier, or be fused into one comparator in which the second address word acts as an inverse bit mask for the first. On an abort the block hands back the fault status and fault address that the fault registers should capture. On a breakpoint it hands back the debug status word with the entry-reason field filled in. All results are registered once. Taking the exception or entering the debug handler is left to the surrounding logic.

Top module: `dacc_guard`

## Requirements
- R1: Every result appears on the clock edge that samples `acc_valid` high, with `out_valid` high for that one cycle. A cycle without the strobe yields `out_valid`, `abort_req` and `bkpt_hit` low and all data outputs zero.
- R2: If process ID bits 31:25 are nonzero and request address bits 31:25 are all zero, `out_addr` is the request address with the ID bits placed in bits 31:25. Otherwise `out_addr` equals the request address. Every later check uses `out_addr`.
- R3: When control bit 1 is set and `out_addr` bits 1:0 are nonzero, `abort_req` is high, `fault_status` holds the fault code 1 and `fault_addr` holds `out_addr`. Without an abort, both fault outputs are zero.
- R4: Each watch unit has a 2-bit qualifier with these meanings: 0 means off, 1 means stores only, 2 means loads and stores, 3 means loads only. `acc_store` high marks a store.
- R5: With breakpoint-control bit 8 clear, watch unit 0 uses qualifier bits 1:0 and matches when `out_addr` bits 31:2 equal breakpoint-0 bits 31:2.
- R6: With breakpoint-control bit 8 clear, watch unit 1 uses qualifier bits 3:2 and matches the same way against breakpoint 1.
- R7: With breakpoint-control bit 8 set, only qualifier bits 1:0 apply and a match needs `(out_addr & ~bp1) == (bp0 & ~bp1)`. Watch unit 1 never matches on its own in this mode.
- R8: When debug status bit 31 is set, no breakpoint is reported for that access and `dstat_val` equals the incoming debug status.
- R9: On a breakpoint, `dstat_val` is the incoming debug status with bits 4:2 replaced by the code 3'b010. On any other valid access it equals the incoming debug status unchanged.
- R10: An access that matches both watch units gives a single one-cycle `bkpt_hit` pulse.
- R11: While `rst` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | AW | Requested data address |
| acc_store | input | 1 | 1 = store, 0 = load |
| pid_reg | input | AW | Process identifier register value |
| ctl_reg | input | CW | System control register value (bit 1 = alignment check) |
| bkpt0_reg | input | AW | Breakpoint address 0 |
| bkpt1_reg | input | AW | Breakpoint address 1 or inverse mask |
| bkctl_reg | input | CW | Breakpoint control (qualifiers, mask mode bit) |
| dstat_in | input | AW | Debug control/status value (bit 31 = debug on) |
| out_valid | output | 1 | Registered result strobe |
| out_addr | output | AW | Relocated address |
| abort_req | output | 1 | Alignment abort request |
| fault_status | output | AW | Fault status to capture |
| fault_addr | output | AW | Fault address to capture |
| bkpt_hit | output | 1 | Data breakpoint taken |
| dstat_val | output | AW | Debug status with entry reason |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 7-bit relocation field from bit 25, word granularity and the mask variant generated in. Building it that way brings both the independent-unit comparison and the fused mask comparison within reach, along with relocation carried into both. Random addresses are drawn near the breakpoint words so that matches, near misses one word away and unaligned low bits occur often. Directed cases cover each qualifier code, the debug-on override and a double match.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

   // Watch unit qualifier codes
   typedef enum logic [1:0] {
      WEN_OFF   = 2'd0,
      WEN_STORE = 2'd1,
      WEN_BOTH  = 2'd2,
      WEN_LOAD  = 2'd3
   } wen_e;

   function automatic logic wen_allows(input wen_e en, input logic is_store);
      logic ok;
      case (en)
         WEN_OFF:   ok = 1'b0;
         WEN_STORE: ok = is_store;
         WEN_LOAD:  ok = !is_store;
         default:   ok = 1'b1;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/dacc_relocate.sv
module dacc_relocate #(
   parameter int AW     = 32,
   parameter int ID_LSB = 25
) (
   input  logic [AW-1:0] addr_in,
   input  logic [AW-1:0] pid,
   output logic [AW-1:0] addr_out
);
   localparam int IDW = AW - ID_LSB;

   logic [IDW-1:0] slot;
   logic [IDW-1:0] top;
   logic           unused_pid;

   assign slot       = pid[AW-1:ID_LSB];
   assign top        = addr_in[AW-1:ID_LSB];
   assign unused_pid = ^pid[ID_LSB-1:0];

   always_comb begin
      addr_out = addr_in;
      if ((slot != '0) && (top == '0))
         addr_out[AW-1:ID_LSB] = slot;
   end
endmodule

// File: rtl/dacc_align_chk.sv
module dacc_align_chk #(
   parameter int AW        = 32,
   parameter int CW        = 32,
   parameter int GRAN_BITS = 2,
   parameter int ALIGN_BIT = 1
) (
   input  logic [AW-1:0] addr,
   input  logic [CW-1:0] ctl,
   output logic          misaligned
);
   logic unused_ctl;
   logic unused_addr;

   assign unused_ctl  = ^ctl;
   assign unused_addr = ^addr[AW-1:GRAN_BITS];
   assign misaligned  = ctl[ALIGN_BIT] && (addr[GRAN_BITS-1:0] != '0);
endmodule

// File: rtl/dacc_watch_unit.sv
module dacc_watch_unit
   import dacc_pkg::*;
#(
   parameter int AW        = 32,
   parameter int CW        = 32,
   parameter int GRAN_BITS = 2,
   parameter bit MASK_EN   = 1'b1,
   parameter int MASK_BIT  = 8,
   parameter int EN0_LSB   = 0,
   parameter int EN1_LSB   = 2
) (
   input  logic [AW-1:0] addr,
   input  logic          is_store,
   input  logic [AW-1:0] bp0,
   input  logic [AW-1:0] bp1,
   input  logic [CW-1:0] bctl,
   output logic          hit
);
   localparam int NUNIT = 2;

   logic [AW-1:0]    bp [NUNIT];
   logic [NUNIT-1:0] unit_hit;
   logic             unused_bctl;

   assign bp[0]       = bp0;
   assign bp[1]       = bp1;
   assign unused_bctl = ^bctl;

   for (genvar g = 0; g < NUNIT; g++) begin : g_unit
      localparam int LSB = (g == 0) ? EN0_LSB : EN1_LSB;
      wen_e en;
      assign en          = wen_e'(bctl[LSB +: 2]);
      assign unit_hit[g] = wen_allows(en, is_store) &&
                           (addr[AW-1:GRAN_BITS] == bp[g][AW-1:GRAN_BITS]);
   end

   if (MASK_EN) begin : g_mask
      wen_e en0;
      logic mask_on;
      logic mask_hit;
      assign en0      = wen_e'(bctl[EN0_LSB +: 2]);
      assign mask_on  = bctl[MASK_BIT];
      assign mask_hit = wen_allows(en0, is_store) &&
                        ((addr & ~bp1) == (bp0 & ~bp1));
      assign hit      = mask_on ? mask_hit : (|unit_hit);
   end else begin : g_plain
      assign hit = |unit_hit;
   end
endmodule

// File: rtl/dacc_guard.sv
module dacc_guard #(
   parameter int AW         = 32,
   parameter int CW         = 32,
   parameter int ID_LSB     = 25,
   parameter int GRAN_BITS  = 2,
   parameter int ALIGN_BIT  = 1,
   parameter bit MASK_EN    = 1'b1,
   parameter int MASK_BIT   = 8,
   parameter int EN0_LSB    = 0,
   parameter int EN1_LSB    = 2,
   parameter int DBG_BIT    = 31,
   parameter int MOE_LSB    = 2,
   parameter int MOE_W      = 3,
   parameter int MOE_CODE   = 2,
   parameter int FAULT_CODE = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          acc_valid,
   input  logic [AW-1:0] acc_addr,
   input  logic          acc_store,
   input  logic [AW-1:0] pid_reg,
   input  logic [CW-1:0] ctl_reg,
   input  logic [AW-1:0] bkpt0_reg,
   input  logic [AW-1:0] bkpt1_reg,
   input  logic [CW-1:0] bkctl_reg,
   input  logic [AW-1:0] dstat_in,
   output logic          out_valid,
   output logic [AW-1:0] out_addr,
   output logic          abort_req,
   output logic [AW-1:0] fault_status,
   output logic [AW-1:0] fault_addr,
   output logic          bkpt_hit,
   output logic [AW-1:0] dstat_val
);
   localparam logic [MOE_W-1:0] MOE_V   = MOE_CODE[MOE_W-1:0];
   localparam logic [AW-1:0]    FAULT_V = AW'(FAULT_CODE);

   // Elaboration-time parameter checks
   if (ID_LSB <= GRAN_BITS || ID_LSB >= AW) begin : g_bad_id
      $error("ID_LSB must lie between GRAN_BITS and AW");
   end
   if (ALIGN_BIT >= CW || MASK_BIT >= CW) begin : g_bad_ctl
      $error("control bit positions exceed CW");
   end
   if (EN0_LSB + 2 > CW || EN1_LSB + 2 > CW) begin : g_bad_en
      $error("qualifier fields exceed CW");
   end
   if (DBG_BIT >= AW || MOE_LSB + MOE_W > AW) begin : g_bad_dbg
      $error("debug status fields exceed AW");
   end

   logic [AW-1:0] reloc_addr;
   logic          mis;
   logic          raw_hit;
   logic          take_hit;
   logic [AW-1:0] dstat_next;

   dacc_relocate #(.AW(AW), .ID_LSB(ID_LSB)) u_reloc (
      .addr_in (acc_addr),
      .pid     (pid_reg),
      .addr_out(reloc_addr)
   );

   dacc_align_chk #(.AW(AW), .CW(CW), .GRAN_BITS(GRAN_BITS),
                    .ALIGN_BIT(ALIGN_BIT)) u_align (
      .addr      (reloc_addr),
      .ctl       (ctl_reg),
      .misaligned(mis)
   );

   dacc_watch_unit #(.AW(AW), .CW(CW), .GRAN_BITS(GRAN_BITS), .MASK_EN(MASK_EN),
                     .MASK_BIT(MASK_BIT), .EN0_LSB(EN0_LSB),
                     .EN1_LSB(EN1_LSB)) u_watch (
      .addr    (reloc_addr),
      .is_store(acc_store),
      .bp0     (bkpt0_reg),
      .bp1     (bkpt1_reg),
      .bctl    (bkctl_reg),
      .hit     (raw_hit)
   );

   // Breakpoints are suppressed while debug is on
   assign take_hit = raw_hit && !dstat_in[DBG_BIT];

   always_comb begin
      dstat_next = dstat_in;
      if (take_hit)
         dstat_next[MOE_LSB +: MOE_W] = MOE_V;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid    <= 1'b0;
         out_addr     <= '0;
         abort_req    <= 1'b0;
         fault_status <= '0;
         fault_addr   <= '0;
         bkpt_hit     <= 1'b0;
         dstat_val    <= '0;
      end else begin
         out_valid    <= acc_valid;
         out_addr     <= acc_valid ? reloc_addr : '0;
         abort_req    <= acc_valid && mis;
         fault_status <= (acc_valid && mis) ? FAULT_V : '0;
         fault_addr   <= (acc_valid && mis) ? reloc_addr : '0;
         bkpt_hit     <= acc_valid && take_hit;
         dstat_val    <= acc_valid ? dstat_next : '0;
      end
   end
endmodule

// File: rtl/dacc_guard_chk.sv
module dacc_guard_chk #(
   parameter int AW         = 32,
   parameter int ID_LSB     = 25,
   parameter int GRAN_BITS  = 2,
   parameter int DBG_BIT    = 31,
   parameter int MOE_LSB    = 2,
   parameter int MOE_W      = 3,
   parameter int MOE_CODE   = 2,
   parameter int FAULT_CODE = 1
) (
   input logic          clk,
   input logic          rst,
   input logic          acc_valid,
   input logic [AW-1:0] acc_addr,
   input logic [AW-1:0] dstat_in,
   input logic          out_valid,
   input logic [AW-1:0] out_addr,
   input logic          abort_req,
   input logic [AW-1:0] fault_status,
   input logic [AW-1:0] fault_addr,
   input logic          bkpt_hit,
   input logic [AW-1:0] dstat_val
);
   // R1: no strobe, no result
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(acc_valid) |-> (!out_valid && !abort_req && !bkpt_hit));

   // R3: abort carries code and address
   assert_abort_capture_R3: assert property (@(posedge clk) disable iff (rst)
      abort_req |-> (fault_addr == out_addr && fault_status == AW'(FAULT_CODE)));

   // R3: aligned result never aborts
   assert_aligned_no_abort_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_addr[GRAN_BITS-1:0] == '0) |-> !abort_req);

   // R2: high addresses pass unchanged
   assert_high_passthru_R2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(acc_addr[AW-1:ID_LSB]) != '0) |-> out_addr == $past(acc_addr));

   // R8: debug on suppresses breakpoints
   assert_debug_blocks_R8: assert property (@(posedge clk) disable iff (rst)
      $past(acc_valid && dstat_in[DBG_BIT]) |-> !bkpt_hit);

   // R9: entry reason written on a hit
   assert_moe_code_R9: assert property (@(posedge clk) disable iff (rst)
      bkpt_hit |-> dstat_val[MOE_LSB +: MOE_W] == MOE_CODE[MOE_W-1:0]);

   // R9: status untouched without a hit
   assert_status_kept_R9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !bkpt_hit) |-> dstat_val == $past(dstat_in));
endmodule

bind dacc_guard dacc_guard_chk #(
   .AW(AW), .ID_LSB(ID_LSB), .GRAN_BITS(GRAN_BITS), .DBG_BIT(DBG_BIT),
   .MOE_LSB(MOE_LSB), .MOE_W(MOE_W), .MOE_CODE(MOE_CODE), .FAULT_CODE(FAULT_CODE)
) u_chk (
   .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
   .dstat_in(dstat_in), .out_valid(out_valid), .out_addr(out_addr),
   .abort_req(abort_req), .fault_status(fault_status), .fault_addr(fault_addr),
   .bkpt_hit(bkpt_hit), .dstat_val(dstat_val)
);

// File: tb/sim_dacc_guard.sv
module sim_dacc_guard;
   logic        clk = 1'b0;
   logic        rst;
   logic        acc_valid;
   logic [31:0] acc_addr;
   logic        acc_store;
   logic [31:0] pid_reg, ctl_reg, bkpt0_reg, bkpt1_reg, bkctl_reg, dstat_in;
   logic        out_valid, abort_req, bkpt_hit;
   logic [31:0] out_addr, fault_status, fault_addr, dstat_val;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #10 clk = ~clk;

   dacc_guard u0 (
      .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_store(acc_store), .pid_reg(pid_reg), .ctl_reg(ctl_reg),
      .bkpt0_reg(bkpt0_reg), .bkpt1_reg(bkpt1_reg), .bkctl_reg(bkctl_reg),
      .dstat_in(dstat_in), .out_valid(out_valid), .out_addr(out_addr),
      .abort_req(abort_req), .fault_status(fault_status), .fault_addr(fault_addr),
      .bkpt_hit(bkpt_hit), .dstat_val(dstat_val)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic        abort;
      logic [31:0] fsr;
      logic [31:0] far;
      logic        hit;
      logic [31:0] ds;
   } exp_t;

   function automatic bit allow(input logic [1:0] q, input bit st);
      return (q == 2'd2) || (q == 2'd1 && st) || (q == 2'd3 && !st);
   endfunction

   function automatic exp_t model(input logic [31:0] a_in, input bit st,
                                  input logic [31:0] p, c, b0, b1, bc, ds);
      exp_t e;
      logic [31:0] a;
      a = a_in;
      if (p[31:25] != 0 && a_in[31:25] == 0) a[31:25] = p[31:25];
      e.addr  = a;
      e.abort = c[1] && (a[1:0] != 0);
      e.fsr   = e.abort ? 32'd1 : 32'd0;
      e.far   = e.abort ? a : 32'd0;
      e.hit   = 1'b0;
      if (!ds[31]) begin
         if (bc[8])
            e.hit = allow(bc[1:0], st) && ((a & ~b1) == (b0 & ~b1));
         else
            e.hit = (allow(bc[1:0], st) && a[31:2] == b0[31:2]) ||
                    (allow(bc[3:2], st) && a[31:2] == b1[31:2]);
      end
      e.ds = ds;
      if (e.hit) e.ds[4:2] = 3'b010;
      return e;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog act=%0d exp=%0d", cyc, 100000);
         finish_run();
      end
   end

   // Drive one access at a negedge, check results at the next negedge
   task automatic access(input logic [31:0] a, input bit st,
                         input logic [31:0] p, c, b0, b1, bc, ds, input string hreq);
      exp_t e;
      acc_valid = 1'b1; acc_addr = a; acc_store = st; pid_reg = p; ctl_reg = c;
      bkpt0_reg = b0; bkpt1_reg = b1; bkctl_reg = bc; dstat_in = ds;
      e = model(a, st, p, c, b0, b1, bc, ds);
      @(negedge clk);
      acc_valid = 1'b0;
      chk(out_valid == 1'b1, "R1 valid", 32'(out_valid), 32'd1);
      chk(out_addr == e.addr, "R2 addr", out_addr, e.addr);
      chk(abort_req == e.abort, "R3 abort", 32'(abort_req), 32'(e.abort));
      chk(fault_status == e.fsr, "R3 fsr", fault_status, e.fsr);
      chk(fault_addr == e.far, "R3 far", fault_addr, e.far);
      chk(bkpt_hit == e.hit, hreq, 32'(bkpt_hit), 32'(e.hit));
      chk(dstat_val == e.ds, "R9 dstat", dstat_val, e.ds);
   endtask

   task automatic idle_check(input string req);
      acc_valid = 1'b0;
      @(negedge clk);
      chk(!out_valid && !abort_req && !bkpt_hit, req,
          {29'd0, out_valid, abort_req, bkpt_hit}, 32'd0);
      chk(out_addr == 0 && dstat_val == 0, req, out_addr | dstat_val, 32'd0);
   endtask

   initial begin
      rst = 1'b1; acc_valid = 1'b0; acc_addr = '0; acc_store = 1'b0;
      pid_reg = '0; ctl_reg = '0; bkpt0_reg = '0; bkpt1_reg = '0;
      bkctl_reg = '0; dstat_in = '0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!out_valid && !abort_req && !bkpt_hit, "R11 flags",
          {29'd0, out_valid, abort_req, bkpt_hit}, 32'd0);
      chk((out_addr | fault_status | fault_addr | dstat_val) == 0, "R11 data",
          out_addr | fault_status | fault_addr | dstat_val, 32'd0);
      rst = 1'b0;
      @(negedge clk);

      // R2: relocation
      access(32'h0000_1234, 0, 32'h0A00_0000, 0, 0, 0, 0, 0, "R2 hit");
      chk(out_addr == 32'h0A00_1234, "R2 reloc", out_addr, 32'h0A00_1234);
      access(32'h4000_1234, 0, 32'h0A00_0000, 0, 0, 0, 0, 0, "R2 hit");
      chk(out_addr == 32'h4000_1234, "R2 high kept", out_addr, 32'h4000_1234);
      access(32'h0000_1234, 0, 32'h01FF_FFFF, 0, 0, 0, 0, 0, "R2 hit");
      chk(out_addr == 32'h0000_1234, "R2 zero id", out_addr, 32'h0000_1234);

      // R3: alignment
      access(32'h0000_1001, 1, 0, 32'h2, 0, 0, 0, 0, "R3 hit");
      chk(abort_req && fault_addr == 32'h1001, "R3 abort", fault_addr, 32'h1001);
      access(32'h0000_1000, 1, 0, 32'h2, 0, 0, 0, 0, "R3 hit");
      access(32'h0000_1003, 1, 0, 32'h0, 0, 0, 0, 0, "R3 hit");
      access(32'h0000_0002, 0, 32'h0600_0000, 32'h2, 0, 0, 0, 0, "R3 hit");

      // R4: qualifier encodings on unit 0
      access(32'h2000, 1, 0, 0, 32'h2000, 0, 32'h1, 0, "R4 store-only store");
      access(32'h2000, 0, 0, 0, 32'h2000, 0, 32'h1, 0, "R4 store-only load");
      access(32'h2000, 0, 0, 0, 32'h2000, 0, 32'h3, 0, "R4 load-only load");
      access(32'h2000, 1, 0, 0, 32'h2000, 0, 32'h3, 0, "R4 load-only store");
      access(32'h2000, 1, 0, 0, 32'h2000, 0, 32'h2, 0, "R4 both store");
      access(32'h2000, 0, 0, 0, 32'h2000, 0, 32'h0, 0, "R4 off");

      // R5: word compare on unit 0
      access(32'h2003, 0, 0, 0, 32'h2000, 0, 32'h2, 0, "R5 same word");
      chk(bkpt_hit == 1'b1, "R5 same word hit", 32'(bkpt_hit), 32'd1);
      access(32'h2004, 0, 0, 0, 32'h2000, 0, 32'h2, 0, "R5 next word");

      // R6: unit 1 with qualifier bits 3:2
      access(32'h3002, 1, 0, 0, 32'h0, 32'h3000, 32'h8, 0, "R6 unit1 hit");
      chk(bkpt_hit == 1'b1, "R6 unit1", 32'(bkpt_hit), 32'd1);
      access(32'h3002, 1, 0, 0, 32'h0, 32'h3000, 32'hC, 0, "R6 unit1 load-only");

      // R7: mask mode
      access(32'h4000_1234, 0, 0, 0, 32'h4000_0000, 32'h0000_FFFF, 32'h102, 0, "R7 mask hit");
      chk(bkpt_hit == 1'b1, "R7 masked", 32'(bkpt_hit), 32'd1);
      access(32'h4001_0000, 0, 0, 0, 32'h4000_0000, 32'h0000_FFFF, 32'h102, 0, "R7 mask miss");
      access(32'h0000_FFFC, 0, 0, 0, 32'h4000_0000, 32'h0000_FFFC, 32'h108, 0, "R7 unit1 ignored");
      chk(bkpt_hit == 1'b0, "R7 unit1 off", 32'(bkpt_hit), 32'd0);

      // R8: debug on suppresses
      access(32'h2000, 0, 0, 0, 32'h2000, 0, 32'h2, 32'h8000_0000, "R8 debug on");
      chk(dstat_val == 32'h8000_0000, "R8 status", dstat_val, 32'h8000_0000);

      // R9: entry reason field
      access(32'h2000, 0, 0, 0, 32'h2000, 0, 32'h2, 32'h0000_001F, "R9 hit");
      chk(dstat_val == 32'h0000_000B, "R9 field", dstat_val, 32'h0000_000B);

      // R10: double match, one pulse
      access(32'h5000, 1, 0, 0, 32'h5000, 32'h5000, 32'hA, 0, "R10 double");
      chk(bkpt_hit == 1'b1, "R10 pulse", 32'(bkpt_hit), 32'd1);
      idle_check("R10 pulse ends");

      // R1: idle cycles
      idle_check("R1 idle");

      // Random accesses
      void'($urandom(32'd20240607));
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] b0, b1, a, p, c, bc, ds;
         bit st;
         b0 = $urandom(); b1 = $urandom();
         if ($urandom_range(3) == 0) b0[31:25] = 0;
         if ($urandom_range(3) == 0) b1 = 32'h0000_FFFF >> $urandom_range(15);
         case ($urandom_range(3))
            0: a = b0 ^ {28'd0, 4'($urandom_range(15))};
            1: a = b1 ^ {29'd0, 3'($urandom_range(7))};
            2: a = {7'd0, b0[24:0]};
            default: a = $urandom();
         endcase
         p  = ($urandom_range(1) == 0) ? 32'd0 : $urandom();
         c  = {30'd0, 1'($urandom_range(1)), 1'b0};
         bc = {23'd0, 1'($urandom_range(1)), 4'd0, 4'($urandom_range(15))};
         ds = $urandom();
         if ($urandom_range(3) != 0) ds[31] = 1'b0;
         st = 1'($urandom_range(1));
         access(a, st, p, c, b0, b1, bc, ds, "R4 R5 R6 R7 random");
         if ($urandom_range(7) == 0) idle_check("R1 random idle");
      end

      finish_run();
   end
endmodule